// File: doc/BRIEF.md
# SDRAM Row Activation Timing Guard

This block sits between a command source and an SDRAM command bus. Each cycle it looks at one requested command (ACTIVE, READ, WRITE, PRECHARGE or anything else) and decides whether that command may go out now under the row activation rules. It keeps track of which of the four banks currently hold an open row. It also keeps saturating age counters that give the number of cycles since the last ACTIVE to each bank, and since the last ACTIVE to any bank.

When the request is legal, the guard raises `req_ready` and drives the command onto the bus in the same cycle. When it is not legal, `req_ready` stays low and the bus carries a NOP.

The request side follows valid/ready rules, with three points:
- `req_ready` is computed from the request fields alone, so it is meaningful whenever `req_valid` is high.
- A transfer takes place only in a cycle where both are high.
- While stalled, the source may keep holding the request or may replace it. The guard never latches a request, so a held request simply waits until it becomes legal.

The three spacing limits are given as picosecond parameters. At elaboration each is turned into a cycle count by dividing by the clock period and rounding up.

Top module: `sdram_act_guard`

## Requirements
- R1: Each cycle limit equals the ceiling of its picosecond limit divided by `TCK_PS`. With the defaults (`TCK_PS`=7000, tRCD 15000, tRC 60000, tRRD 14000) the limits are 3, 9 and 2 cycles.
- R2: `req_cmd` carries {cs_n, ras_n, cas_n, we_n} on bits [3:0]. The codes are ACTIVE=4'b0011, READ=4'b0101, WRITE=4'b0100, PRECHARGE=4'b0010 and NOP=4'b0111.
- R3: A READ or WRITE to a bank with no open row is never granted.
- R4: A READ or WRITE to an open bank is granted only when at least tRCD cycles have elapsed since that bank's ACTIVE. An ACTIVE granted in cycle t allows a column command in cycle t+3 at the earliest with the default limits.
- R5: An ACTIVE to a bank that already has an open row is stalled until that bank is precharged. A granted ACTIVE opens its bank.
- R6: Two granted ACTIVEs to the same bank are at least tRC cycles apart.
- R7: Any two granted ACTIVEs, to any banks, are at least tRRD cycles apart.
- R8: PRECHARGE is always granted. It closes `req_ba`, or closes all banks when `req_addr[10]` is 1, effective from the next cycle.
- R9: When `req_valid` or `req_ready` is low, the bus shows NOP (4'b0111) with bank and address zero. When both are high, the bus carries the request's code, bank and address in that same cycle.
- R10: Any other code, NOP included, is always ready and is forwarded unchanged. It alters no bank state and no counter.
- R11: After reset all banks are closed and every age counter is saturated, so the first ACTIVE is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A command is requested this cycle |
| req_cmd | input | 4 | Requested {cs_n, ras_n, cas_n, we_n} |
| req_ba | input | 2 | Requested bank |
| req_addr | input | 13 | Row, column or precharge-all address |
| req_ready | output | 1 | The request is legal this cycle |
| sd_cs_n | output | 1 | Bus chip select, active low |
| sd_ras_n | output | 1 | Bus row strobe, active low |
| sd_cas_n | output | 1 | Bus column strobe, active low |
| sd_we_n | output | 1 | Bus write enable, active low |
| sd_ba | output | 2 | Bus bank address |
| sd_addr | output | 13 | Bus address |

## Verification
The bench first runs directed sequences.
- An ACTIVE followed by a READ that is held until granted. This separates an off-by-one in tRCD counting from a correct count, because the grant must land exactly three cycles after the ACTIVE.
- A repeated ACTIVE to the same bank, with a precharge inserted later. This tells the open-row stall apart from the tRC stall.
- A precharge-all followed by a READ. This shows whether the wide close reached every bank.

A long random phase then mixes every command code over all four banks with short request gaps. It exercises tRRD against tRC interplay and unknown-code forwarding. A cycle-level model compares ready and the whole bus on every clock.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_NOP = 4'b0111;

  // R1: limit in ps to cycles, rounded up
  function automatic int unsigned ps_to_cyc(input int unsigned lim_ps, input int unsigned tck_ps);
    return (lim_ps + tck_ps - 1) / tck_ps;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sag_age_ctr.sv
module sag_age_ctr #(
  parameter int unsigned CW   = 4,
  parameter int unsigned CMAX = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [CW-1:0] age
);
  localparam logic [CW-1:0] SAT = CW'(CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)          age <= SAT;
    else if (load)       age <= CW'(1);
    else if (age < SAT)  age <= age + CW'(1);
  end

  a_r11_saturated_bound: assert property (@(posedge clk) disable iff (!rst_n)
    age <= SAT);
  a_r6_age_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> age >= $past(age));
endmodule

// File: rtl/sag_banks.sv
module sag_banks #(
  parameter int unsigned NB   = 4,
  parameter int unsigned CW   = 4,
  parameter int unsigned CMAX = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NB-1:0]          act_oh,
  input  logic [NB-1:0]          pre_oh,
  output logic [NB-1:0]          bank_open,
  output logic [NB-1:0][CW-1:0]  bank_age
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    sag_age_ctr #(.CW(CW), .CMAX(CMAX)) u_age (
      .clk  (clk),
      .rst_n(rst_n),
      .load (act_oh[b]),
      .age  (bank_age[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)         bank_open[b] <= 1'b0;
      else if (act_oh[b]) bank_open[b] <= 1'b1;
      else if (pre_oh[b]) bank_open[b] <= 1'b0;
    end

    a_r5_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
      act_oh[b] |-> !bank_open[b]);
    a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      act_oh[b] |=> (bank_open[b] && bank_age[b] == CW'(1)));
    a_r8_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_oh[b] && !act_oh[b]) |=> !bank_open[b]);
  end

  a_r2_one_act: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_oh));
endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import sag_pkg::*;
#(
  parameter int unsigned TCK_PS   = 7000,
  parameter int unsigned TRCD_PS  = 15000,
  parameter int unsigned TRC_PS   = 60000,
  parameter int unsigned TRRD_PS  = 14000,
  parameter int unsigned BAW      = 2,
  parameter int unsigned AW       = 13,
  parameter int unsigned PALL_BIT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_cmd,
  input  logic [BAW-1:0] req_ba,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          sd_cs_n,
  output logic          sd_ras_n,
  output logic          sd_cas_n,
  output logic          sd_we_n,
  output logic [BAW-1:0] sd_ba,
  output logic [AW-1:0] sd_addr
);
  localparam int unsigned NB     = 1 << BAW;
  localparam int unsigned TRCD_C = ps_to_cyc(TRCD_PS, TCK_PS);
  localparam int unsigned TRC_C  = ps_to_cyc(TRC_PS, TCK_PS);
  localparam int unsigned TRRD_C = ps_to_cyc(TRRD_PS, TCK_PS);
  localparam int unsigned CMAX   = max3(TRCD_C, TRC_C, TRRD_C);
  localparam int unsigned CW     = $clog2(CMAX + 1);
  localparam logic [CW-1:0] TRCD_W = CW'(TRCD_C);
  localparam logic [CW-1:0] TRC_W  = CW'(TRC_C);
  localparam logic [CW-1:0] TRRD_W = CW'(TRRD_C);

  logic [NB-1:0]         bank_open;
  logic [NB-1:0][CW-1:0] bank_age;
  logic [CW-1:0]         any_age;
  logic [NB-1:0]         act_oh, pre_oh;
  logic is_act, is_col, is_pre, legal, fire, sel_open;
  logic [CW-1:0] sel_age;

  assign is_act   = (req_cmd == CMD_ACT);
  assign is_col   = (req_cmd == CMD_RD) || (req_cmd == CMD_WR);
  assign is_pre   = (req_cmd == CMD_PRE);
  assign sel_open = bank_open[req_ba];
  assign sel_age  = bank_age[req_ba];

  always_comb begin
    if (is_act)      legal = !sel_open && (sel_age >= TRC_W) && (any_age >= TRRD_W);
    else if (is_col) legal = sel_open && (sel_age >= TRCD_W);
    else             legal = 1'b1;
  end

  assign req_ready = legal;
  assign fire      = req_valid && legal;

  always_comb begin
    act_oh = '0;
    pre_oh = '0;
    if (fire && is_act) act_oh[req_ba] = 1'b1;
    if (fire && is_pre) begin
      if (req_addr[PALL_BIT]) pre_oh = '1;
      else                    pre_oh[req_ba] = 1'b1;
    end
  end

  sag_banks #(.NB(NB), .CW(CW), .CMAX(CMAX)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_oh   (act_oh),
    .pre_oh   (pre_oh),
    .bank_open(bank_open),
    .bank_age (bank_age)
  );

  sag_age_ctr #(.CW(CW), .CMAX(CMAX)) u_any_age (
    .clk  (clk),
    .rst_n(rst_n),
    .load (fire && is_act),
    .age  (any_age)
  );

  always_comb begin
    if (fire) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = req_cmd;
      sd_ba   = req_ba;
      sd_addr = req_addr;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = CMD_NOP;
      sd_ba   = '0;
      sd_addr = '0;
    end
  end

  a_r9_stall_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP && sd_addr == '0));
  a_r7_any_age_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_act) |=> any_age == CW'(1));
  a_r3_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_col) |-> bank_open[req_ba]);
  a_r10_other_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_act && !is_pre) |=> $stable(bank_open));
endmodule

// File: tb/tb_sdram_act_guard.sv
module tb_sdram_act_guard;
  localparam int TCK = 7000, TRCDP = 15000, TRCP = 60000, TRRDP = 14000;
  localparam int TRCD = (TRCDP + TCK - 1) / TCK;
  localparam int TRC  = (TRCP + TCK - 1) / TCK;
  localparam int TRRD = (TRRDP + TCK - 1) / TCK;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [3:0] req_cmd = 4'b0111;
  logic [1:0] req_ba = 0;
  logic [12:0] req_addr = 0;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;

  sdram_act_guard dut (.*);

  always #2ns clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int last_act[4];
  int last_any;
  bit open_m[4];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h cyc=%0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0011: return "R5/R6/R7";
      4'b0101, 4'b0100: return "R3/R4";
      4'b0010: return "R8";
      default: return "R10";
    endcase
  endfunction

  // one clock: drive, compare against model, advance model; returns grant
  task automatic step(input bit v, input logic [3:0] c, input logic [1:0] b, input logic [12:0] a, output bit g);
    bit exp_rdy;
    logic [18:0] exp_bus;
    @(negedge clk);
    req_valid = v; req_cmd = c; req_ba = b; req_addr = a;
    #1;
    if (c == 4'b0011)
      exp_rdy = !open_m[b] && (cyc - last_act[b] >= TRC) && (cyc - last_any >= TRRD);
    else if (c == 4'b0101 || c == 4'b0100)
      exp_rdy = open_m[b] && (cyc - last_act[b] >= TRCD);
    else
      exp_rdy = 1;
    g = v && exp_rdy;
    exp_bus = g ? {c, b, a} : {4'b0111, 2'b00, 13'd0};
    chk(req_ready == exp_rdy, tag_of(c), "ready", req_ready, exp_rdy);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr} == exp_bus, "R9", "bus",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr}, exp_bus);
    if (g && c == 4'b0011) begin open_m[b] = 1; last_act[b] = cyc; last_any = cyc; end
    if (g && c == 4'b0010) begin
      if (a[10]) for (int i = 0; i < 4; i++) open_m[i] = 0;
      else open_m[b] = 0;
    end
    cyc++;
  endtask

  task automatic hold(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a, input int maxc, output int at);
    bit g;
    at = -1;
    for (int i = 0; i < maxc; i++) begin
      step(1, c, b, a, g);
      if (g) begin at = cyc - 1; break; end
    end
  endtask

  initial begin
    int t_act, t_col, t2, t3;
    bit g;
    for (int i = 0; i < 4; i++) begin last_act[i] = -1000; open_m[i] = 0; end
    last_any = -1000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R11: reset state, first ACTIVE at once
    step(1, 4'b0011, 2'd0, 13'd5, g);
    chk(g == 1 && req_ready == 1, "R11", "first act", req_ready, 1);
    t_act = cyc - 1;
    // R4: column at exactly tRCD after ACTIVE
    hold(4'b0101, 2'd0, 13'd8, 10, t_col);
    chk(t_col - t_act == TRCD, "R4", "trcd delta", t_col - t_act, TRCD);
    chk(TRCD == 3 && TRC == 9 && TRRD == 2, "R1", "cycles", {TRCD, TRC, TRRD}, {32'd3, 32'd9, 32'd2});
    // R7: cross-bank spacing
    hold(4'b0011, 2'd1, 13'd7, 10, t2);
    hold(4'b0011, 2'd2, 13'd9, 10, t3);
    chk(t3 - t2 == TRRD, "R7", "trrd delta", t3 - t2, TRRD);
    // R5: ACTIVE to open bank stalls
    hold(4'b0011, 2'd0, 13'd6, 12, t2);
    chk(t2 == -1, "R5", "act open bank", t2, -1);
    // R8 then R6
    hold(4'b0010, 2'd0, 13'd0, 1, t2);
    chk(t2 != -1, "R8", "pre granted", t2, 0);
    hold(4'b0011, 2'd0, 13'd6, 20, t2);
    chk(t2 - t_act >= TRC, "R6", "trc spacing", t2 - t_act, TRC);
    // R8 precharge all, R3 read closed
    hold(4'b0010, 2'd3, 13'h400, 1, t2);
    hold(4'b0100, 2'd1, 13'd1, 12, t2);
    chk(t2 == -1, "R3", "read closed", t2, -1);
    // R10 other code
    hold(4'b0001, 2'd2, 13'h1abc, 1, t2);
    chk(t2 != -1, "R10", "other code", t2, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [3:0] c;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: c = 4'b0011;
        3, 4:    c = 4'b0101;
        5:       c = 4'b0100;
        6:       c = 4'b0010;
        7:       c = 4'b0111;
        8:       c = 4'b0001;
        default: c = 4'b1111;
      endcase
      step($urandom_range(0, 3) != 0, c, 2'($urandom_range(0, 3)), 13'($urandom_range(0, 8191)), g);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule